// File: doc/BRIEF.md
# Clock domain wakeup controller

This block holds the control and status word of a single clock domain. Software sets a two-bit transition field to wake the domain or put it to sleep. While the domain is awake, the block drives an enable for each of its gated clocks. Each clock then has its own ramp period before it counts as running. When that period ends, the clock's activity bit in the status word rises. Software polls these bits one at a time and uses the domain only once every clock it needs reads active.

The activity bits are independent of each other. A bit counts its ramp only while its upstream ready input is high. It drops at once if that input falls while the domain is awake. After a forced sleep, the enables turn off on the next cycle, but the activity bits keep their value for a fixed drain period before they clear. The ramp lengths, the drain period and the number of clocks are elaboration parameters.

Top module: `clkdom_wake_ctrl`

## Requirements
- R1: After reset, every clock enable is 0 and the status word reads 0: transition field 0, no activity bit set.
- R2: A write whose bits [1:0] equal 2 (wake) sets every clock enable to 1 in the next cycle, and the transition field then reads 2.
- R3: With its ready input held high, the activity bit of clock k (status bit 4+k) reads 1 exactly RAMP_k cycles after the wake write is taken, and 0 in every earlier cycle. Clocks with different ramps assert at different cycles.
- R4: An activity bit ramps only while its enable and its ready input are both high. A clock whose ready is low keeps its bit at 0 while the other bits assert. When ready rises, the bit reads 1 RAMP_k-1 cycles after the first edge that samples ready high.
- R5: If ready of clock k falls while the domain is awake, its activity bit reads 0 from the next cycle. When ready returns, the ramp restarts from zero.
- R6: A write whose bits [1:0] equal 1 (sleep) clears every enable in the next cycle. The activity bits hold their values for SLEEP_LAT cycles after the write is taken, then read 0.
- R7: A write whose bits [1:0] equal 0 (hold) changes neither the enables nor the activity bits. The transition field then reads 0.
- R8: A write whose bits [1:0] equal 3 is ignored entirely: the transition field, the enables and the activity bits keep their values.
- R9: Write data bits [31:2] have no effect, including the activity-bit positions. Reads return the live status word: field at [1:0], activity of clock k at bit 4+k, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Live register read value |
| clk_ready_i | input | NUM_CLK | Upstream ready, one per gated clock |
| clk_en_o | output | NUM_CLK | Gated-clock enables |

## Verification
The wake sequence is first run with every clock ready. This separates the three ramp lengths by the exact cycle each bit rises, and it catches a bit that asserts one cycle early or late. The same wake is then repeated with one clock held not-ready. This shows that the bits are independent and that ramping waits on the ready input. A ready drop in the middle of operation shows the immediate clear and the restart from zero. Hold, reserved and sleep writes, each carrying junk in the upper data bits, tell the hold-state path, the ignore path and the drain delay apart.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
  typedef enum logic [1:0] {
    TC_HOLD  = 2'd0,
    TC_SLEEP = 2'd1,
    TC_WAKE  = 2'd2,
    TC_RSVD  = 2'd3
  } tc_e;

  localparam int ACT_LSB = 4;
  localparam int MAX_CLK = 3;
endpackage

// File: rtl/clkdom_ctrl_reg.sv
module clkdom_ctrl_reg
  import clkdom_pkg::*;
#(
  parameter int SLEEP_LAT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_tc_i,
  output tc_e        tc_o,
  output logic       awake_o,
  output logic       drain_done_o
);
  localparam int DRAIN_W = $clog2(SLEEP_LAT + 1);

  tc_e               tc_q;
  logic              awake_q;
  logic [DRAIN_W-1:0] drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q    <= TC_HOLD;
      awake_q <= 1'b0;
      drain_q <= '0;
    end else begin
      if (drain_q != '0) drain_q <= drain_q - 1'b1;
      if (wr_en_i && tc_e'(wr_tc_i) != TC_RSVD) begin
        tc_q <= tc_e'(wr_tc_i);
        unique case (tc_e'(wr_tc_i))
          TC_SLEEP: begin
            awake_q <= 1'b0;
            drain_q <= DRAIN_W'(SLEEP_LAT);
          end
          TC_WAKE: begin
            awake_q <= 1'b1;
            drain_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign tc_o         = tc_q;
  assign awake_o      = awake_q;
  // activity clears on the edge that ends the drain window
  assign drain_done_o = !awake_q && (drain_q <= DRAIN_W'(1));
endmodule

// File: rtl/clkdom_ramp.sv
module clkdom_ramp #(
  parameter int RAMP  = 3,
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ready_i,
  input  logic drain_done_i,
  output logic act_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en_i && ready_i) begin
      if (!act_q) begin
        if (cnt_q == CNT_W'(RAMP - 1)) act_q <= 1'b1;
        else                           cnt_q <= cnt_q + 1'b1;
      end
    end else if (en_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= '0;
      if (drain_done_i) act_q <= 1'b0;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/clkdom_wake_ctrl.sv
module clkdom_wake_ctrl
  import clkdom_pkg::*;
#(
  parameter int          NUM_CLK   = 3,
  parameter int          RAMP_W    = 8,
  parameter logic [23:0] RAMP_CYC  = {8'd10, 8'd6, 8'd3},
  parameter int          SLEEP_LAT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_CLK-1:0] clk_ready_i,
  output logic [NUM_CLK-1:0] clk_en_o
);
  tc_e                tc;
  logic               awake;
  logic               drain_done;
  logic [NUM_CLK-1:0] act;
  logic               wr_unused;

  assign wr_unused = ^wr_data_i[31:2];

  clkdom_ctrl_reg #(.SLEEP_LAT(SLEEP_LAT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_tc_i      (wr_data_i[1:0]),
    .tc_o         (tc),
    .awake_o      (awake),
    .drain_done_o (drain_done)
  );

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
    clkdom_ramp #(
      .RAMP  (int'(RAMP_CYC[k*RAMP_W +: RAMP_W])),
      .CNT_W (RAMP_W)
    ) u_ramp (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (awake),
      .ready_i      (clk_ready_i[k]),
      .drain_done_i (drain_done),
      .act_o        (act[k])
    );
    assign clk_en_o[k] = awake;
  end

  always_comb begin
    rd_data_o      = '0;
    rd_data_o[1:0] = tc;
    for (int k = 0; k < NUM_CLK; k++) rd_data_o[ACT_LSB + k] = act[k];
  end
endmodule

// File: rtl/clkdom_wake_ctrl_chk.sv
module clkdom_wake_ctrl_chk
  import clkdom_pkg::*;
#(
  parameter int NUM_CLK = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [31:0]        wr_data_i,
  input logic [31:0]        rd_data_o,
  input logic [NUM_CLK-1:0] clk_ready_i,
  input logic [NUM_CLK-1:0] clk_en_o
);
  p_wake_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[1:0] == 2'd2 |=> clk_en_o == '1);

  p_sleep_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[1:0] == 2'd1 |=> clk_en_o == '0);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[1:0] == 2'd0 |=> $stable(clk_en_o));

  p_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[1:0] == 2'd3 |=> $stable(rd_data_o[1:0]) && $stable(clk_en_o));

  p_layout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:ACT_LSB+NUM_CLK] == '0 && rd_data_o[3:2] == 2'b00);

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_chk
    p_act_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_data_o[ACT_LSB+k]) |-> $past(clk_en_o[k] && clk_ready_i[k]));

    p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_en_o[k] && !clk_ready_i[k] |=> !rd_data_o[ACT_LSB+k]);
  end
endmodule

bind clkdom_wake_ctrl clkdom_wake_ctrl_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .clk_ready_i (clk_ready_i),
  .clk_en_o    (clk_en_o)
);

// File: tb/clkdom_wake_ctrl_tb.sv
module clkdom_wake_ctrl_tb;
  localparam int NUM_CLK   = 3;
  localparam int SLEEP_LAT = 4;
  localparam int RMP0 = 3, RMP1 = 6, RMP2 = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [31:0]        wr_data = '0;
  logic [31:0]        rd_data;
  logic [NUM_CLK-1:0] ready = '1;
  logic [NUM_CLK-1:0] en;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int          at;
    logic [31:0] rd;
    logic [2:0]  en;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdom_wake_ctrl #(
    .NUM_CLK   (NUM_CLK),
    .RAMP_W    (8),
    .RAMP_CYC  ({8'd10, 8'd6, 8'd3}),
    .SLEEP_LAT (SLEEP_LAT)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .clk_ready_i (ready),
    .clk_en_o    (en)
  );

  task automatic push(input int at, input logic [31:0] rd, input logic [2:0] e, input string req);
    exp_t it;
    it.at = at; it.rd = rd; it.en = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [31:0] d, output int c0);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    c0 = cyc + 1;
  endtask

  task automatic set_ready(input logic [2:0] v, output int c0);
    @(negedge clk);
    wr_en = 1'b0;
    ready = v;
    c0 = cyc + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  // monitor: compare every queued item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        n_chk++;
        if (rd_data !== sb[i].rd || en !== sb[i].en) begin
          n_fail++;
          $display("FAIL %s cyc %0d: rd=%h en=%b expected rd=%h en=%b",
                   sb[i].req, cyc, rd_data, en, sb[i].rd, sb[i].en);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c, r, r2;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_data !== 32'h0 || en !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 in reset: rd=%h en=%b expected rd=0 en=000", rd_data, en);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rd_data !== 32'h0 || en !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 after reset: rd=%h en=%b expected rd=0 en=000", rd_data, en);
    end

    // R2/R3: wake with every clock ready
    wr(32'h0000_0002, c);
    push(c,            32'h02, 3'b111, "R2");
    push(c + RMP0 - 1, 32'h02, 3'b111, "R3");
    push(c + RMP0,     32'h12, 3'b111, "R3");
    push(c + RMP1 - 1, 32'h12, 3'b111, "R3");
    push(c + RMP1,     32'h32, 3'b111, "R3");
    push(c + RMP2 - 1, 32'h32, 3'b111, "R3");
    push(c + RMP2,     32'h72, 3'b111, "R3");
    idle(RMP2 + 2);

    // R7/R9: hold with junk in upper bits, including activity positions
    wr(32'hFFFF_FFF0, c);
    push(c,     32'h70, 3'b111, "R7");
    push(c + 3, 32'h70, 3'b111, "R9");
    idle(4);

    // R8: reserved code ignored
    wr(32'h0000_0073, c);
    push(c,     32'h70, 3'b111, "R8");
    push(c + 2, 32'h70, 3'b111, "R8");
    idle(3);

    // R6: sleep, activity drains
    wr(32'hFFFF_FF01, c);
    push(c,                 32'h71, 3'b000, "R6");
    push(c + SLEEP_LAT - 1, 32'h71, 3'b000, "R6");
    push(c + SLEEP_LAT,     32'h01, 3'b000, "R6");
    push(c + SLEEP_LAT + 2, 32'h01, 3'b000, "R6");
    idle(SLEEP_LAT + 3);

    // R4: clock 1 not ready during wake
    set_ready(3'b101, r);
    wr(32'h0000_0002, c);
    push(c + RMP0,     32'h12, 3'b111, "R4");
    push(c + RMP2,     32'h52, 3'b111, "R4");
    push(c + RMP2 + 1, 32'h52, 3'b111, "R4");
    idle(RMP2 + 2);
    set_ready(3'b111, r);
    push(r + RMP1 - 2, 32'h52, 3'b111, "R4");
    push(r + RMP1 - 1, 32'h72, 3'b111, "R4");
    idle(RMP1 + 2);

    // R5: ready drop on clock 0 while awake, then restart
    set_ready(3'b110, r);
    push(r, 32'h62, 3'b111, "R5");
    set_ready(3'b111, r2);
    push(r2 + RMP0 - 2, 32'h62, 3'b111, "R5");
    push(r2 + RMP0 - 1, 32'h72, 3'b111, "R5");
    idle(RMP0 + 3);

    idle(2);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule